// File: doc/BRIEF.md
# Wait-Mode Clock Loss Supervisor

This block decides how the clock and reset unit of a microcontroller reacts when the external oscillator stops while the device sits in its low-power wait state. A clock monitor reports a failure. Two configuration bits then choose the response: the failure can be ignored, it can raise a clock monitor reset at once, or it can switch the device into self-clock mode. In self-clock mode the PLL is forced on and the system clock is taken from the PLL. A third bit decides whether entering self-clock mode also raises a wakeup interrupt that ends the wait state.

While self-clock mode is active, the block runs a clock-quality check on the oscillator. The check passes only after a full run of oscillator-good ticks with no failure report in between. A failure report restarts the check, so checks repeat for as long as the oscillator stays bad. This continues while the device is in wait mode and after it has left. When a check passes, self-clock mode ends and the clock select returns to the oscillator. The PLL then follows the PLL-in-wait policy bit if the device is still waiting.

The analogue detector, the PLL, the oscillator and the glitch-free clock multiplexer are outside the block. It sees them only as the monitor fail level, an oscillator tick strobe and a multiplexer acknowledge.

Top module: `wcls_supervisor`

## Requirements
- R1: With `cfg_mon_en_i` low and self-clock mode inactive, `mon_fail_i` has no effect: no reset request, no self-clock mode, no flag, and the wait state is kept.
- R2: With `cfg_mon_en_i` high and `cfg_scm_en_i` low, `cm_rst_req_o` is high in the cycle after each cycle in which `mon_fail_i` is sampled high, and the wait state ends on that same edge.
- R3: With both `cfg_mon_en_i` and `cfg_scm_en_i` high, a sampled `mon_fail_i` while self-clock mode is inactive sets `scm_active_o`, `scm_flag_o` and `pll_en_o` on the next edge.
- R4: `wake_irq_o` is high exactly while `scm_flag_o` and `cfg_scm_irq_en_i` are both high. While waiting, a high `wake_irq_o` ends the wait state on the next edge. With the enable low, the wait state is kept.
- R5: Self-clock mode clears on the edge that samples the 4096th consecutive `osc_tick_i` with `mon_fail_i` low (QUAL_CYCLES = 4096). It stays set as long as the oscillator does not recover, inside or outside wait.
- R6: A `mon_fail_i` sampled during a check resets the tick count, so a full 4096 further clean ticks are needed.
- R7: `pll_en_o` is low only while waiting with self-clock mode inactive and `cfg_pll_wait_i` low. Otherwise it is high. `vreg_en_o` is always high.
- R8: `scm_flag_o` stays set until a `flag_clr_i` pulse clears it. A new clock loss in the same cycle as the clear wins and keeps it set. Reset clears it.
- R9: `clk_sel_o` is 1 (PLL) while self-clock mode is active and 0 (oscillator) otherwise. It takes a new value only on an edge where `mux_ack_i` is high, so it lags `scm_active_o` by at least one cycle.
- R10: A `wait_enter_i` pulse sets `wait_active_o`. While waiting, `wake_req_i` clears it. `ext_rst_req_i` clears it and raises `rst_seq_o` for one cycle. `ext_rst_req_i` outside wait gives no `rst_seq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_enter_i | input | 1 | Pulse: enter wait state |
| wake_req_i | input | 1 | Ordinary wakeup request |
| ext_rst_req_i | input | 1 | External reset request |
| mon_fail_i | input | 1 | Clock monitor reports oscillator failure |
| osc_tick_i | input | 1 | One oscillator-good clock counted this cycle |
| cfg_mon_en_i | input | 1 | Clock monitor enable |
| cfg_scm_en_i | input | 1 | Self-clock mode enable |
| cfg_scm_irq_en_i | input | 1 | Self-clock wakeup interrupt enable |
| cfg_pll_wait_i | input | 1 | Keep PLL on during wait |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the flag |
| mux_ack_i | input | 1 | Both clock sources reported stable by the multiplexer |
| cm_rst_req_o | output | 1 | Clock monitor reset request |
| scm_active_o | output | 1 | Self-clock mode active |
| scm_flag_o | output | 1 | Sticky self-clock interrupt flag |
| wake_irq_o | output | 1 | Self-clock wakeup interrupt |
| pll_en_o | output | 1 | PLL enable |
| vreg_en_o | output | 1 | Voltage regulator enable |
| clk_sel_o | output | 1 | System clock source, 0 oscillator, 1 PLL |
| wait_active_o | output | 1 | Device is in wait state |
| rst_seq_o | output | 1 | Start reset sequence |

## Verification
The reset request, the self-clock state, the flag, the wait state and the reset-sequence strobe are registered. Each is due one edge after the input that causes it. The wakeup interrupt and the PLL enable are combinational and appear together with the register they come from. The clock select lags self-clock mode by one more edge, and more if the multiplexer withholds its acknowledge. The quality-check exit is due exactly 4096 edges after the first clean tick. Each stimulus step queues its expectations with the due cycle counted from the step, and the monitor compares them only when the cycle counter reaches that value, halfway between edges. The exit edge is checked on both sides, one cycle before and at the due cycle.

// File: rtl/wcls_pkg.sv
package wcls_pkg;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_PLL = 1'b1
    } clk_src_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_RESET = 2'd1,
        ACT_SCM   = 2'd2
    } loss_act_e;

    typedef struct packed {
        logic wait_act;
        logic scm;
        logic flag;
        logic cm_rst;
        logic rst_seq;
    } sup_state_t;

endpackage

// File: rtl/wcls_loss_decode.sv
module wcls_loss_decode
    import wcls_pkg::*;
(
    input  logic      fail_i,
    input  logic      mon_en_i,
    input  logic      scm_en_i,
    output loss_act_e act_o
);

    always_comb begin
        act_o = ACT_NONE;
        if (fail_i && mon_en_i) begin
            if (scm_en_i) begin
                act_o = ACT_SCM;
            end else begin
                act_o = ACT_RESET;
            end
        end
    end

endmodule

// File: rtl/wcls_qual_check.sv
module wcls_qual_check #(
    parameter int QUAL_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fail_i,
    input  logic tick_i,
    output logic pass_o
);

    localparam int CNT_W = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // A pass is the tick that completes the run of clean ticks.
    assign pass_o = run_i && tick_i && !fail_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || fail_i || pass_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/wcls_clk_switch.sv
module wcls_clk_switch
    import wcls_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     want_pll_i,
    input  logic     ack_i,
    output clk_src_e sel_o
);

    clk_src_e sel_d, sel_q;
    clk_src_e target;

    assign target = want_pll_i ? SRC_PLL : SRC_OSC;

    always_comb begin
        sel_d = sel_q;
        if (ack_i && (target != sel_q)) begin
            sel_d = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SRC_OSC;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/wcls_supervisor.sv
module wcls_supervisor
    import wcls_pkg::*;
#(
    parameter int QUAL_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_enter_i,
    input  logic wake_req_i,
    input  logic ext_rst_req_i,
    input  logic mon_fail_i,
    input  logic osc_tick_i,
    input  logic cfg_mon_en_i,
    input  logic cfg_scm_en_i,
    input  logic cfg_scm_irq_en_i,
    input  logic cfg_pll_wait_i,
    input  logic flag_clr_i,
    input  logic mux_ack_i,
    output logic cm_rst_req_o,
    output logic scm_active_o,
    output logic scm_flag_o,
    output logic wake_irq_o,
    output logic pll_en_o,
    output logic vreg_en_o,
    output logic clk_sel_o,
    output logic wait_active_o,
    output logic rst_seq_o
);

    sup_state_t st_d, st_q;
    loss_act_e  act;
    logic       qual_pass;
    logic       loss_scm;
    logic       wake_irq;
    clk_src_e   sel;

    wcls_loss_decode u_decode (
        .fail_i   (mon_fail_i),
        .mon_en_i (cfg_mon_en_i),
        .scm_en_i (cfg_scm_en_i),
        .act_o    (act)
    );

    wcls_qual_check #(
        .QUAL_CYCLES (QUAL_CYCLES)
    ) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.scm),
        .fail_i (mon_fail_i),
        .tick_i (osc_tick_i),
        .pass_o (qual_pass)
    );

    wcls_clk_switch u_switch (
        .clk        (clk),
        .rst_n      (rst_n),
        .want_pll_i (st_q.scm),
        .ack_i      (mux_ack_i),
        .sel_o      (sel)
    );

    assign loss_scm = (act == ACT_SCM) && !st_q.scm;
    assign wake_irq = st_q.flag && cfg_scm_irq_en_i;

    always_comb begin
        st_d         = st_q;
        st_d.cm_rst  = (act == ACT_RESET);
        st_d.rst_seq = 1'b0;

        // Self-clock mode: entry on loss, exit on a passed quality check.
        if (loss_scm) begin
            st_d.scm = 1'b1;
        end else if (st_q.scm && qual_pass) begin
            st_d.scm = 1'b0;
        end

        // Sticky flag: a new loss takes priority over the clear pulse.
        if (loss_scm) begin
            st_d.flag = 1'b1;
        end else if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end

        // Wait state: every exit takes priority over entry.
        if (st_q.wait_act) begin
            if (ext_rst_req_i) begin
                st_d.wait_act = 1'b0;
                st_d.rst_seq  = 1'b1;
            end else if (wake_req_i || wake_irq || (act == ACT_RESET)) begin
                st_d.wait_act = 1'b0;
            end
        end else if (wait_enter_i) begin
            st_d.wait_act = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cm_rst_req_o  = st_q.cm_rst;
    assign scm_active_o  = st_q.scm;
    assign scm_flag_o    = st_q.flag;
    assign wake_irq_o    = wake_irq;
    assign pll_en_o      = st_q.scm || !st_q.wait_act || cfg_pll_wait_i;
    assign vreg_en_o     = 1'b1;
    assign clk_sel_o     = (sel == SRC_PLL);
    assign wait_active_o = st_q.wait_act;
    assign rst_seq_o     = st_q.rst_seq;

endmodule

// File: rtl/wcls_supervisor_chk.sv
module wcls_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_rst_req_i,
    input logic mon_fail_i,
    input logic cfg_mon_en_i,
    input logic cfg_scm_en_i,
    input logic flag_clr_i,
    input logic mux_ack_i,
    input logic cm_rst_req_o,
    input logic scm_active_o,
    input logic scm_flag_o,
    input logic wake_irq_o,
    input logic clk_sel_o,
    input logic wait_active_o,
    input logic rst_seq_o
);

    a_r1_ignore_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mon_en_i && !scm_active_o) |=> (!scm_active_o && !cm_rst_req_o));

    a_r2_cm_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_fail_i && cfg_mon_en_i && !cfg_scm_en_i) |=> cm_rst_req_o);

    a_r3_scm_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_fail_i && cfg_mon_en_i && cfg_scm_en_i && !scm_active_o)
            |=> (scm_active_o && scm_flag_o));

    a_r4_irq_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq_o && wait_active_o) |=> !wait_active_o);

    a_r5_fail_blocks_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (scm_active_o && mon_fail_i) |=> scm_active_o);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (scm_flag_o && !flag_clr_i) |=> scm_flag_o);

    a_r9_sel_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_ack_i |=> $stable(clk_sel_o));

    a_r10_ext_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_active_o && ext_rst_req_i) |=> (rst_seq_o && !wait_active_o));

endmodule

bind wcls_supervisor wcls_supervisor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_rst_req_i (ext_rst_req_i),
    .mon_fail_i    (mon_fail_i),
    .cfg_mon_en_i  (cfg_mon_en_i),
    .cfg_scm_en_i  (cfg_scm_en_i),
    .flag_clr_i    (flag_clr_i),
    .mux_ack_i     (mux_ack_i),
    .cm_rst_req_o  (cm_rst_req_o),
    .scm_active_o  (scm_active_o),
    .scm_flag_o    (scm_flag_o),
    .wake_irq_o    (wake_irq_o),
    .clk_sel_o     (clk_sel_o),
    .wait_active_o (wait_active_o),
    .rst_seq_o     (rst_seq_o)
);

// File: tb/wcls_supervisor_tb_top.sv
`timescale 1ns/1ps
module wcls_supervisor_tb_top;

    typedef enum int {
        S_CM, S_SCM, S_FLAG, S_IRQ, S_PLL, S_VREG, S_SEL, S_WAIT, S_RSTSEQ
    } sig_e;

    typedef struct {
        int    due;
        sig_e  sig;
        logic  exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_enter = 0, wake_req = 0, ext_rst_req = 0, mon_fail = 0, osc_tick = 0;
    logic cfg_mon_en = 0, cfg_scm_en = 0, cfg_irq_en = 0, cfg_pll_wait = 0;
    logic flag_clr = 0, mux_ack = 1;
    logic cm_rst_req, scm_active, scm_flag, wake_irq, pll_en, vreg_en, clk_sel;
    logic wait_active, rst_seq;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    item_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wcls_supervisor dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .wait_enter_i     (wait_enter),
        .wake_req_i       (wake_req),
        .ext_rst_req_i    (ext_rst_req),
        .mon_fail_i       (mon_fail),
        .osc_tick_i       (osc_tick),
        .cfg_mon_en_i     (cfg_mon_en),
        .cfg_scm_en_i     (cfg_scm_en),
        .cfg_scm_irq_en_i (cfg_irq_en),
        .cfg_pll_wait_i   (cfg_pll_wait),
        .flag_clr_i       (flag_clr),
        .mux_ack_i        (mux_ack),
        .cm_rst_req_o     (cm_rst_req),
        .scm_active_o     (scm_active),
        .scm_flag_o       (scm_flag),
        .wake_irq_o       (wake_irq),
        .pll_en_o         (pll_en),
        .vreg_en_o        (vreg_en),
        .clk_sel_o        (clk_sel),
        .wait_active_o    (wait_active),
        .rst_seq_o        (rst_seq)
    );

    function automatic logic read_sig(sig_e s);
        case (s)
            S_CM:     return cm_rst_req;
            S_SCM:    return scm_active;
            S_FLAG:   return scm_flag;
            S_IRQ:    return wake_irq;
            S_PLL:    return pll_en;
            S_VREG:   return vreg_en;
            S_SEL:    return clk_sel;
            S_WAIT:   return wait_active;
            default:  return rst_seq;
        endcase
    endfunction

    // Driver side: queue an expectation due 'off' cycles after the current step.
    task automatic expect_at(int off, sig_e s, logic e, string tag);
        item_t it;
        int    pos;
        it.due = cyc + off;
        it.sig = s;
        it.exp = e;
        it.tag = tag;
        pos = sb_q.size();
        for (int i = 0; i < sb_q.size(); i++) begin
            if (sb_q[i].due > it.due) begin
                pos = i;
                break;
            end
        end
        sb_q.insert(pos, it);
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Monitor side: compare queued items halfway between edges.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            logic  act;
            it  = sb_q.pop_front();
            act = read_sig(it.sig);
            checks++;
            if (it.due != cyc || act !== it.exp) begin
                errors++;
                $display("FAIL %s: signal %s actual %0b expected %0b (due %0d, now %0d)",
                         it.tag, it.sig.name(), act, it.exp, it.due, cyc);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // Reset state
        expect_at(0, S_SCM, 0, "R3 reset");
        expect_at(0, S_FLAG, 0, "R8 reset");
        expect_at(0, S_CM, 0, "R2 reset");
        expect_at(0, S_SEL, 0, "R9 reset");
        expect_at(0, S_WAIT, 0, "R10 reset");
        expect_at(0, S_PLL, 1, "R7 reset");
        expect_at(0, S_VREG, 1, "R7 reset");
        step(1);

        // R1: monitor disabled, loss ignored
        wait_enter = 1;
        expect_at(1, S_WAIT, 1, "R10 enter");
        step(1);
        wait_enter = 0;
        expect_at(0, S_PLL, 0, "R7 wait no pll");
        mon_fail = 1;
        expect_at(1, S_CM, 0, "R1");
        expect_at(1, S_SCM, 0, "R1");
        expect_at(2, S_FLAG, 0, "R1");
        expect_at(2, S_WAIT, 1, "R1");
        step(3);
        mon_fail = 0;

        // R2: immediate clock monitor reset
        cfg_mon_en = 1;
        mon_fail = 1;
        expect_at(1, S_CM, 1, "R2");
        expect_at(1, S_WAIT, 0, "R2");
        expect_at(1, S_SCM, 0, "R2");
        step(1);
        mon_fail = 0;
        expect_at(1, S_CM, 0, "R2");
        step(2);

        // R3/R5/R6: self-clock mode without interrupt
        cfg_scm_en = 1;
        wait_enter = 1;
        step(1);
        wait_enter = 0;
        mon_fail = 1;
        expect_at(1, S_SCM, 1, "R3");
        expect_at(1, S_FLAG, 1, "R3");
        expect_at(1, S_PLL, 1, "R3");
        expect_at(1, S_IRQ, 0, "R4");
        expect_at(1, S_SEL, 0, "R9 lag");
        expect_at(2, S_SEL, 1, "R9");
        expect_at(2, S_WAIT, 1, "R4 no irq");
        step(1);
        mon_fail = 0;
        osc_tick = 1;
        step(100);
        mon_fail = 1;
        expect_at(1, S_SCM, 1, "R6");
        step(1);
        mon_fail = 0;
        expect_at(4095, S_SCM, 1, "R6");
        expect_at(4096, S_SCM, 0, "R5");
        expect_at(4096, S_PLL, 0, "R7");
        expect_at(4096, S_FLAG, 1, "R8");
        expect_at(4097, S_SEL, 0, "R9");
        expect_at(4097, S_VREG, 1, "R7");
        step(4100);
        osc_tick = 0;
        flag_clr = 1;
        expect_at(1, S_FLAG, 0, "R8");
        step(1);
        flag_clr = 0;
        wake_req = 1;
        expect_at(1, S_WAIT, 0, "R10 wake");
        expect_at(1, S_RSTSEQ, 0, "R10 wake");
        step(1);
        wake_req = 0;
        expect_at(0, S_PLL, 1, "R7 out of wait");
        step(1);

        // R4/R8/R9: interrupt wakeup, set beats clear, held acknowledge
        cfg_irq_en = 1;
        wait_enter = 1;
        step(1);
        wait_enter = 0;
        mon_fail = 1;
        flag_clr = 1;
        mux_ack = 0;
        expect_at(1, S_FLAG, 1, "R8 set wins");
        expect_at(1, S_IRQ, 1, "R4");
        expect_at(1, S_WAIT, 1, "R4");
        expect_at(2, S_WAIT, 0, "R4");
        expect_at(2, S_SEL, 0, "R9 no ack");
        expect_at(5, S_SEL, 0, "R9 no ack");
        step(1);
        flag_clr = 0;
        step(4);
        mux_ack = 1;
        expect_at(1, S_SEL, 1, "R9 ack");
        step(1);
        step(50);
        expect_at(0, S_SCM, 1, "R5 no recovery");
        expect_at(0, S_PLL, 1, "R7 scm");
        flag_clr = 1;
        expect_at(1, S_FLAG, 0, "R8");
        expect_at(1, S_IRQ, 0, "R4");
        step(1);
        flag_clr = 0;
        mon_fail = 0;
        osc_tick = 1;
        expect_at(4095, S_SCM, 1, "R5");
        expect_at(4096, S_SCM, 0, "R5");
        expect_at(4097, S_SEL, 0, "R9");
        step(4098);
        osc_tick = 0;

        // R10: external reset in and out of wait, PLL kept by policy
        cfg_pll_wait = 1;
        wait_enter = 1;
        step(1);
        wait_enter = 0;
        expect_at(0, S_PLL, 1, "R7 pll in wait");
        ext_rst_req = 1;
        expect_at(1, S_RSTSEQ, 1, "R10 ext");
        expect_at(1, S_WAIT, 0, "R10 ext");
        step(1);
        ext_rst_req = 0;
        expect_at(1, S_RSTSEQ, 0, "R10 pulse");
        step(3);
        ext_rst_req = 1;
        expect_at(1, S_RSTSEQ, 0, "R10 outside wait");
        step(1);
        ext_rst_req = 0;
        step(3);

        while (sb_q.size() > 0) step(1);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule